// File: doc/BRIEF.md
# Short-Frame-Sync PCM Serial Port

A full-duplex serial port that carries one 8-bit voice sample per frame in each direction over a shared bit clock. Transmit and receive each have their own frame-sync input. Both syncs and the bit clock are phase-locked to each other at a nominal 8 kHz frame rate. The bit clock can run at any rate from 64 kHz to 2048 kHz, including 200 kHz and 1544 kHz. The port runs on a fast system clock and sees the bit clock, both syncs and the serial input as sampled levels. One synchronizer chain aligns all four of them, so they keep their relative phase.

On the transmit side a sync rising edge captures the parallel byte. The byte is shifted out most significant bit first, one bit per bit-clock rising edge. The serial output is open-drain: `sdo_low_o` high means the pin is pulled low (a 0 bit), and low means the pin is released (a 1 bit, or no slot). The first bit goes out at once if the sync rises while the bit clock is high. If the bit clock is low, the first bit waits for the next rising edge.

On the receive side a sync rising edge marks the word boundary. The next eight bit-clock falling edges sample the serial input, most significant bit first, and the finished word is presented with a one-cycle strobe. A power-save input aborts both directions and keeps the output released.

The transmit state machine has three states:
- `TX_IDLE`: the output is released.
- `TX_ARM`: a sync was seen while the bit clock was low.
- `TX_SHIFT`: a slot is being driven.

Its transitions are:
- sync-rise → `TX_SHIFT` (bit clock high) or `TX_ARM` (bit clock low), from any state.
- `TX_ARM` → `TX_SHIFT` on a bit-clock rise.
- `TX_SHIFT` → `TX_SHIFT` on a bit-clock rise while bits remain.
- `TX_SHIFT` → `TX_IDLE` on the bit-clock rise after the last bit.
- power-save → `TX_IDLE`.

The receive state machine has two states, `RX_IDLE` and `RX_SHIFT`. Its transitions are:
- sync-rise → `RX_SHIFT` with the bit count cleared, from any state.
- `RX_SHIFT` → `RX_IDLE` on the eighth falling edge, raising the strobe.
- power-save → `RX_IDLE`.

Top module: `pcm_sfs_port`

## Requirements
- R1: After reset the output is released (`sdo_low_o`=0), `rx_valid_o` is 0 and `rx_byte_o` is 0.
- R2: A transmit sync rising edge seen while the bit clock is high launches the MSB immediately. Each later bit-clock rising edge launches the next bit, so the first bit is shortened by the sync's delay after the clock rise.
- R3: A transmit sync rising edge seen while the bit clock is low launches the MSB at the next bit-clock rising edge, and that bit lasts one full bit period.
- R4: The output is pulled low only for 0 bits inside the 8-bit slot. It is released from the bit-clock rising edge that follows the eighth bit.
- R5: The transmit byte is captured at the sync rising edge. Changes on `tx_byte_i` during the slot have no effect on the bits sent.
- R6: After a receive sync rising edge, the next 8 bit-clock falling edges sample `sdi_i` MSB first into `rx_byte_o`. A line with no slot reads as 1, since it is released.
- R7: Each completed receive word raises `rx_valid_o` for exactly one system-clock cycle.
- R8: A sync rising edge during an unfinished slot restarts that direction. Transmit recaptures the byte and starts from its MSB; receive discards the partial word.
- R9: While `pwr_save_i` is high, the output stays released and no word is reported. Normal frames resume once it drops.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the bit clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwr_save_i | input | 1 | Power save: abort both directions, release output |
| bclk_i | input | 1 | Shared serial bit clock |
| tx_sync_i | input | 1 | Transmit frame sync, rising edge starts a slot |
| rx_sync_i | input | 1 | Receive frame sync, rising edge marks word boundary |
| sdi_i | input | 1 | Serial receive data |
| tx_byte_i | input | WORD_W (8) | Parallel byte to transmit |
| sdo_low_o | output | 1 | Open-drain pull-low enable for the serial output |
| rx_byte_o | output | WORD_W (8) | Last received word |
| rx_valid_o | output | 1 | One-cycle strobe for a new received word |

## Verification
The hardest states to reach are the phase-dependent ones. These are a transmit sync that lands while the bit clock is already high, which gives a shortened first bit, and a sync that lands mid-slot and must restart the shifter. The bench derives the bit clock from a counter and aligns every sync to a known phase of that counter. It places transmit syncs at several offsets in the high and low halves of the bit period and counts pulled-low cycles against the exact expected duration. The transmit output loops back to the receive input, and receive syncs are staggered by whole bit periods. Each staggered receive word is then a predictable mix of shifted data and released ones. A second sync pulse three bits into a frame exercises the restart path.

// File: rtl/pcm_sfs_pkg.sv
package pcm_sfs_pkg;

    typedef enum logic [1:0] {
        TX_IDLE  = 2'd0,
        TX_ARM   = 2'd1,
        TX_SHIFT = 2'd2
    } tx_state_e;

    typedef enum logic {
        RX_IDLE  = 1'b0,
        RX_SHIFT = 1'b1
    } rx_state_e;

    // bit positions of the sampled input bundle
    localparam int IN_BCLK  = 0;
    localparam int IN_TXS   = 1;
    localparam int IN_RXS   = 2;
    localparam int IN_SDI   = 3;
    localparam int IN_COUNT = 4;

endpackage

// File: rtl/pcm_sfs_insync.sv
module pcm_sfs_insync #(
    parameter int N      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] raw_i,
    output logic [N-1:0] level_o,
    output logic [N-1:0] rise_o,
    output logic [N-1:0] fall_o
);

    logic [STAGES-1:0][N-1:0] stage_q;
    logic [N-1:0]             prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= '0;
            prev_q  <= '0;
        end else begin
            stage_q[0] <= raw_i;
            for (int s = 1; s < STAGES; s++) begin
                stage_q[s] <= stage_q[s-1];
            end
            prev_q <= stage_q[STAGES-1];
        end
    end

    assign level_o = stage_q[STAGES-1];

    generate
        for (genvar b = 0; b < N; b++) begin : g_edge
            assign rise_o[b] =  level_o[b] & ~prev_q[b];
            assign fall_o[b] = ~level_o[b] &  prev_q[b];
        end
    endgenerate

endmodule

// File: rtl/pcm_sfs_tx.sv
module pcm_sfs_tx
    import pcm_sfs_pkg::*;
#(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_save_i,
    input  logic              bclk_lvl_i,
    input  logic              bclk_rise_i,
    input  logic              sync_rise_i,
    input  logic [WORD_W-1:0] byte_i,
    output logic              sdo_low_o
);

    localparam int CNT_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);

    tx_state_e         state_q, state_d;
    logic [CNT_W-1:0]  idx_q, idx_d;
    logic [WORD_W-1:0] sh_q, sh_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TX_IDLE;
            idx_q   <= '0;
            sh_q    <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
            sh_q    <= sh_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        sh_d    = sh_q;
        if (pwr_save_i) begin
            state_d = TX_IDLE;
            idx_d   = '0;
        end else if (sync_rise_i) begin
            sh_d    = byte_i;
            idx_d   = '0;
            state_d = bclk_lvl_i ? TX_SHIFT : TX_ARM;
        end else begin
            unique case (state_q)
                TX_IDLE: state_d = TX_IDLE;
                TX_ARM: begin
                    if (bclk_rise_i) begin
                        state_d = TX_SHIFT;
                        idx_d   = '0;
                    end
                end
                TX_SHIFT: begin
                    if (bclk_rise_i) begin
                        if (idx_q == LAST_BIT) begin
                            state_d = TX_IDLE;
                        end else begin
                            idx_d = idx_q + CNT_W'(1);
                            sh_d  = {sh_q[WORD_W-2:0], 1'b1};
                        end
                    end
                end
                default: state_d = TX_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        sdo_low_o = (state_q == TX_SHIFT) && !sh_q[WORD_W-1];
    end

    // R9
    tx_pwr_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_save_i |=> !sdo_low_o);

    // R3
    tx_arm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TX_ARM && !bclk_rise_i && !sync_rise_i && !pwr_save_i)
        |=> (state_q == TX_ARM && !sdo_low_o));

    // R4
    tx_bit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TX_SHIFT && !bclk_rise_i && !sync_rise_i && !pwr_save_i)
        |=> $stable(sdo_low_o));

    // R2
    tx_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_rise_i && bclk_lvl_i && !pwr_save_i) |=> (sdo_low_o == !$past(byte_i[WORD_W-1])));

endmodule

// File: rtl/pcm_sfs_rx.sv
module pcm_sfs_rx
    import pcm_sfs_pkg::*;
#(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_save_i,
    input  logic              bclk_fall_i,
    input  logic              sync_rise_i,
    input  logic              sdi_i,
    output logic [WORD_W-1:0] byte_o,
    output logic              valid_o
);

    localparam int CNT_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);

    rx_state_e         state_q, state_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic [WORD_W-1:0] sh_q, sh_d;
    logic [WORD_W-1:0] word_q, word_d;
    logic              valid_q, valid_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RX_IDLE;
            cnt_q   <= '0;
            sh_q    <= '0;
            word_q  <= '0;
            valid_q <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            sh_q    <= sh_d;
            word_q  <= word_d;
            valid_q <= valid_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        sh_d    = sh_q;
        word_d  = word_q;
        valid_d = 1'b0;
        if (pwr_save_i) begin
            state_d = RX_IDLE;
            cnt_d   = '0;
        end else if (sync_rise_i) begin
            state_d = RX_SHIFT;
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                RX_IDLE: state_d = RX_IDLE;
                RX_SHIFT: begin
                    if (bclk_fall_i) begin
                        sh_d = {sh_q[WORD_W-2:0], sdi_i};
                        if (cnt_q == LAST_BIT) begin
                            word_d  = sh_d;
                            valid_d = 1'b1;
                            state_d = RX_IDLE;
                        end else begin
                            cnt_d = cnt_q + CNT_W'(1);
                        end
                    end
                end
                default: state_d = RX_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        byte_o  = word_q;
        valid_o = valid_q;
    end

    // R7
    rx_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    // R6
    rx_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> $past(bclk_fall_i));

    // R8
    rx_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_rise_i && !pwr_save_i) |=> (state_q == RX_SHIFT && cnt_q == '0 && !valid_o));

    // R9
    rx_pwr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_save_i |=> (!valid_o && $stable(byte_o)));

endmodule

// File: rtl/pcm_sfs_port.sv
module pcm_sfs_port
    import pcm_sfs_pkg::*;
#(
    parameter int WORD_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_save_i,
    input  logic              bclk_i,
    input  logic              tx_sync_i,
    input  logic              rx_sync_i,
    input  logic              sdi_i,
    input  logic [WORD_W-1:0] tx_byte_i,
    output logic              sdo_low_o,
    output logic [WORD_W-1:0] rx_byte_o,
    output logic              rx_valid_o
);

    logic [IN_COUNT-1:0] raw;
    logic [IN_COUNT-1:0] lvl;
    logic [IN_COUNT-1:0] rise;
    logic [IN_COUNT-1:0] fall;

    always_comb begin
        raw          = '0;
        raw[IN_BCLK] = bclk_i;
        raw[IN_TXS]  = tx_sync_i;
        raw[IN_RXS]  = rx_sync_i;
        raw[IN_SDI]  = sdi_i;
    end

    pcm_sfs_insync #(
        .N      (IN_COUNT),
        .STAGES (SYNC_STAGES)
    ) u_insync (
        .clk     (clk),
        .rst_n   (rst_n),
        .raw_i   (raw),
        .level_o (lvl),
        .rise_o  (rise),
        .fall_o  (fall)
    );

    pcm_sfs_tx #(
        .WORD_W (WORD_W)
    ) u_tx (
        .clk         (clk),
        .rst_n       (rst_n),
        .pwr_save_i  (pwr_save_i),
        .bclk_lvl_i  (lvl[IN_BCLK]),
        .bclk_rise_i (rise[IN_BCLK]),
        .sync_rise_i (rise[IN_TXS]),
        .byte_i      (tx_byte_i),
        .sdo_low_o   (sdo_low_o)
    );

    pcm_sfs_rx #(
        .WORD_W (WORD_W)
    ) u_rx (
        .clk         (clk),
        .rst_n       (rst_n),
        .pwr_save_i  (pwr_save_i),
        .bclk_fall_i (fall[IN_BCLK]),
        .sync_rise_i (rise[IN_RXS]),
        .sdi_i       (lvl[IN_SDI]),
        .byte_o      (rx_byte_o),
        .valid_o     (rx_valid_o)
    );

    logic unused_edges;
    assign unused_edges = ^{lvl[IN_TXS], lvl[IN_RXS], rise[IN_SDI],
                            fall[IN_TXS], fall[IN_RXS], fall[IN_SDI]};

    // R1
    port_reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!sdo_low_o && !rx_valid_o));

endmodule

// File: tb/tb_pcm_sfs_port.sv
`timescale 1ns/1ps
module tb_pcm_sfs_port;

    logic       clk      = 1'b0;
    logic       rst_n    = 1'b0;
    logic       pwr_save = 1'b0;
    logic       tx_sync  = 1'b0;
    logic       rx_sync  = 1'b0;
    logic [7:0] tx_byte  = 8'h00;
    logic [3:0] ph       = 4'd0;
    logic       bclk;
    logic       sdo_low;
    logic       sdi;
    logic [7:0] rx_byte;
    logic       rx_valid;

    always #4 clk = ~clk;                 // 125 MHz
    always @(negedge clk) ph <= ph + 4'd1;
    assign bclk = ph[3];                  // bit period = 16 system clocks
    assign sdi  = ~sdo_low;               // pull-up loopback

    pcm_sfs_port dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .pwr_save_i (pwr_save),
        .bclk_i     (bclk),
        .tx_sync_i  (tx_sync),
        .rx_sync_i  (rx_sync),
        .sdi_i      (sdi),
        .tx_byte_i  (tx_byte),
        .sdo_low_o  (sdo_low),
        .rx_byte_o  (rx_byte),
        .rx_valid_o (rx_valid)
    );

    int         tests = 0;
    int         fails = 0;
    int         low_tot = 0;
    int         vcyc_tot = 0;
    int         vpul_tot = 0;
    logic       prev_v = 1'b0;
    logic [7:0] last_byte = 8'h00;

    always @(negedge clk) begin
        if (sdo_low) low_tot++;
        if (rx_valid) begin
            vcyc_tot++;
            if (!prev_v) vpul_tot++;
            last_byte = rx_byte;
        end
        prev_v = rx_valid;
    end

    // {byte, sync offset in clocks after bit-clock rise, receive stagger in bits}
    localparam logic [15:0] VEC [8] = '{
        {8'hA5, 4'd1,  4'd0},
        {8'h00, 4'd1,  4'd0},
        {8'hFF, 4'd1,  4'd0},
        {8'h3C, 4'd3,  4'd0},
        {8'h6A, 4'd10, 4'd0},
        {8'h5A, 4'd12, 4'd2},
        {8'hC3, 4'd1,  4'd3},
        {8'h1E, 4'd1,  4'd1}
    };

    task automatic chk(input string rq, input string what, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d (0x%0h) expected %0d (0x%0h)", rq, what, act, act, exp, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    // returns one negedge after a bit-clock rise
    task automatic align();
        @(posedge clk);
        while (ph != 4'd8) @(posedge clk);
        @(negedge clk);
    endtask

    function automatic int exp_low(input logic [7:0] b, input int off);
        int n = 0;
        for (int i = 7; i >= 0; i--) begin
            if (!b[i]) n += (i == 7 && off < 8) ? (16 - off) : 16;
        end
        return n;
    endfunction

    function automatic logic [7:0] exp_rx(input logic [7:0] b, input int k);
        logic [7:0] r = 8'h00;
        for (int j = 0; j < 8; j++) begin
            r = {r[6:0], ((k + j) < 8) ? b[7 - (k + j)] : 1'b1};
        end
        return r;
    endfunction

    task automatic do_frame(input logic [7:0] b, input int off, input int k,
                            output int dlow, output int dpul, output int dcyc);
        int l0, p0, c0;
        align();
        l0 = low_tot; p0 = vpul_tot; c0 = vcyc_tot;
        tx_byte = b;
        fork
            begin
                wait_n(off - 1);
                tx_sync = 1'b1;
                wait_n(16);
                tx_sync = 1'b0;
                wait_n(4);
                tx_byte = ~b;             // mid-slot change must be ignored
            end
            begin
                wait_n(((off >= 8) ? 16 : 0) + 16 * k);
                rx_sync = 1'b1;
                wait_n(16);
                rx_sync = 1'b0;
            end
        join
        wait_n(16 * 12);
        dlow = low_tot - l0;
        dpul = vpul_tot - p0;
        dcyc = vcyc_tot - c0;
    endtask

    initial begin
        repeat (150000) @(negedge clk);
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests + 1, fails + 1);
        $finish;
    end

    initial begin
        int dl, dp, dc;
        wait_n(10);
        rst_n = 1'b1;
        wait_n(4);
        // R1 reset state
        chk("R1", "output released", int'(sdo_low), 0);
        chk("R1", "valid low", int'(rx_valid), 0);
        chk("R1", "rx byte", int'(rx_byte), 0);

        for (int i = 0; i < 8; i++) begin
            logic [7:0] b;
            int off, k;
            b   = VEC[i][15:8];
            off = int'(VEC[i][7:4]);
            k   = int'(VEC[i][3:0]);
            do_frame(b, off, k, dl, dp, dc);
            chk((off < 8) ? "R2" : "R3", "pulled-low cycles", dl, exp_low(b, off));
            chk((k == 0) ? "R5" : "R6", "received byte", int'(last_byte), int'(exp_rx(b, k)));
            chk("R7", "strobe pulses", dp, 1);
            chk("R7", "strobe cycles", dc, 1);
            chk("R4", "released after slot", int'(sdo_low), 0);
        end

        // R8 restart both directions three bits into a frame
        begin
            int l0, p0;
            align();
            l0 = low_tot; p0 = vpul_tot;
            tx_byte = 8'h00;
            tx_sync = 1'b1; rx_sync = 1'b1;
            wait_n(16);
            tx_sync = 1'b0; rx_sync = 1'b0;
            wait_n(32);
            tx_byte = 8'hA5;
            tx_sync = 1'b1; rx_sync = 1'b1;
            wait_n(16);
            tx_sync = 1'b0; rx_sync = 1'b0;
            wait_n(16 * 12);
            chk("R8", "pulled-low cycles", low_tot - l0, 3 * 16 + 4 * 16);
            chk("R8", "strobe pulses", vpul_tot - p0, 1);
            chk("R8", "received byte", int'(last_byte), 8'hA5);
        end

        // R9 power save holds the port idle
        pwr_save = 1'b1;
        wait_n(8);
        do_frame(8'h00, 1, 0, dl, dp, dc);
        chk("R9", "pulled-low cycles in power save", dl, 0);
        chk("R9", "strobes in power save", dp, 0);
        pwr_save = 1'b0;
        wait_n(8);
        do_frame(8'h81, 1, 0, dl, dp, dc);
        chk("R9", "byte after power save", int'(last_byte), 8'h81);
        chk("R9", "low cycles after power save", dl, exp_low(8'h81, 1));

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule